// File: doc/BRIEF.md
# Two-Digit Multiplexed Hex Counter Display

This block holds an 8-bit count that advances once per second and presents it as two hexadecimal characters on a pair of common-cathode seven-segment digits. Both digits share one set of seven segment lines. The block drives a single digit-select line, and the two digit commons take that line with opposite polarity. The select line is a 50%-duty square wave taken from the system clock by counting. On each phase the segment lines carry the pattern for the nibble that belongs to the digit now lit.

The system clock frequency, the count rate and the select toggle rate are parameters. The defaults are 12 MHz, one count per second and 500 select toggles per second. All timing comes from the one system clock: the one-second event is a single-cycle enable, not a separate clock. The segment register loads on the same edge that moves the select line, so a digit never shows the other digit's pattern.

Top module: `hex_count_display`

## Requirements
- R1: While rst_ni is low, and on release of it, digit_sel_o is 0, the count is 0 and seg_o is 7'h3F (the glyph for 0).
- R2: digit_sel_o toggles exactly once every HALF = CLK_HZ/TOGGLE_HZ clock cycles after reset release, so it is high and low for equal time.
- R3: seg_o bit 0 drives segment A and bit 6 drives segment G (order GFEDCBA), and a 1 lights a segment. The glyph for each nibble is: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, B=7C, C=39, D=5E, E=79, F=71.
- R4: When digit_sel_o is 1, seg_o shows the glyph of count bits [7:4]. When digit_sel_o is 0, seg_o shows the glyph of count bits [3:0].
- R5: The count increments by one exactly once every TICK = CLK_HZ/TICK_HZ cycles, with the first increment at cycle TICK after reset release.
- R6: The count wraps from 8'hFF to 8'h00.
- R7: seg_o and digit_sel_o change on the same edge, so in every cycle seg_o matches the digit that is currently selected and the current count.
- R8: HALF and TICK are derived from the parameters alone. After n edges following release, the expected values are: count = (n/TICK) mod 256 and digit_sel_o = (n/HALF) mod 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| seg_o | output | 7 | Segment lines, GFEDCBA order, 1 lights a segment |
| digit_sel_o | output | 1 | 1 lights the upper digit, 0 lights the lower digit |

## Verification
The bench uses a tiny configuration with TICK=8 and HALF=2. It checks every cycle through a full 256-value cycle of the count and past its wrap, so every glyph appears on both digits. A wrong table entry or swapped nibbles shows up as a seg_o mismatch. An off-by-one in either divider shifts the select phase or the moment of increment, and is caught on the first affected cycle. A segment register that lags the select line by one cycle shows the other digit's glyph on every toggle. A broken wrap shows up at count FF. A mid-run asynchronous reset confirms that every counter and the select divider restart from zero.

// File: rtl/hexdisp_pkg.sv
package hexdisp_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned CNT_W   = 2 * DIGIT_W;
  localparam int unsigned SEG_W   = 7;

  typedef logic [SEG_W-1:0]   seg_t;
  typedef logic [DIGIT_W-1:0] nib_t;
  typedef logic [CNT_W-1:0]   cnt_t;

  // GFEDCBA, bit0 = A, active high
  function automatic seg_t hex_glyph(input nib_t n);
    seg_t s;
    case (n)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int unsigned PERIOD = 12_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [W-1:0] c_q;
  logic         last;

  assign last = (c_q == W'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   c_q <= '0;
    else if (last) c_q <= '0;
    else           c_q <= c_q + 1'b1;
  end

  assign tick_o = last;

  generate
    if (PERIOD > 1) begin : g_gap
      // R5
      tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/sel_divider.sv
module sel_divider #(
  parameter int unsigned HALF = 24_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sel_q_o,
  output logic sel_d_o
);
  localparam int unsigned W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [W-1:0] c_q;
  logic         wrap;
  logic         sel_q;

  assign wrap    = (c_q == W'(HALF - 1));
  assign sel_d_o = wrap ? ~sel_q : sel_q;
  assign sel_q_o = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q   <= '0;
      sel_q <= 1'b0;
    end else begin
      c_q   <= wrap ? '0 : c_q + 1'b1;
      sel_q <= sel_d_o;
    end
  end

  // R2
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(sel_q));
  // R2
  sel_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (sel_q != $past(sel_q)));
endmodule

// File: rtl/hex_counter.sv
module hex_counter
  import hexdisp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output cnt_t cnt_q_o,
  output cnt_t cnt_d_o
);
  cnt_t cnt_q;

  assign cnt_d_o = step_i ? cnt_q + 1'b1 : cnt_q;
  assign cnt_q_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d_o;
  end

  // R6
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cnt_q == '1) |=> (cnt_q == '0));
  // R5
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/hex_count_display.sv
module hex_count_display
  import hexdisp_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 12_000_000,
  parameter int unsigned TICK_HZ   = 1,
  parameter int unsigned TOGGLE_HZ = 500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [SEG_W-1:0] seg_o,
  output logic             digit_sel_o
);
  localparam int unsigned TICK_CYC = CLK_HZ / TICK_HZ;
  localparam int unsigned HALF_CYC = CLK_HZ / TOGGLE_HZ;

  logic tick;
  logic sel_q, sel_d;
  cnt_t cnt_q, cnt_d;
  nib_t nib_d, nib_q;
  seg_t seg_q;

  tick_gen #(.PERIOD(TICK_CYC)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  sel_divider #(.HALF(HALF_CYC)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_q_o(sel_q),
    .sel_d_o(sel_d)
  );

  hex_counter u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (tick),
    .cnt_q_o(cnt_q),
    .cnt_d_o(cnt_d)
  );

  // look ahead to next-state values so glyph and select move together
  assign nib_d = sel_d ? cnt_d[CNT_W-1:DIGIT_W] : cnt_d[DIGIT_W-1:0];
  assign nib_q = sel_q ? cnt_q[CNT_W-1:DIGIT_W] : cnt_q[DIGIT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seg_q <= hex_glyph('0);
    else         seg_q <= hex_glyph(nib_d);
  end

  assign seg_o       = seg_q;
  assign digit_sel_o = sel_q;

  // R7
  seg_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_q == hex_glyph(nib_q));
  // R3
  seg_nonblank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(seg_q) >= 2);
endmodule

// File: tb/sim_hex_count_display.sv
module sim_hex_count_display;
  localparam int unsigned CLK_HZ    = 64;
  localparam int unsigned TICK_HZ   = 8;
  localparam int unsigned TOGGLE_HZ = 32;
  localparam int unsigned TICK = CLK_HZ / TICK_HZ;    // 8
  localparam int unsigned HALF = CLK_HZ / TOGGLE_HZ;  // 2

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] seg_o;
  logic       digit_sel_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  hex_count_display #(
    .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .TOGGLE_HZ(TOGGLE_HZ)
  ) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .seg_o(seg_o), .digit_sel_o(digit_sel_o)
  );

  function automatic logic [6:0] ref_glyph(input int n);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[n & 15];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // R8: expected state after n edges since release, from parameters alone
  task automatic chk_cycle(input int n);
    int cnt = (n / TICK) % 256;
    int sel = (n / HALF) % 2;
    int nib = sel ? (cnt >> 4) : (cnt & 15);
    chk("R2 R8 select", int'(digit_sel_o), sel);
    chk("R3 R4 R5 R7 segments", int'(seg_o), int'(ref_glyph(nib)));
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R1 reset state
    chk("R1 select", int'(digit_sel_o), 0);
    chk("R1 segments", int'(seg_o), 'h3F);
    rst_ni = 1'b1;
    chk_cycle(0);
    // full sweep past the wrap: every nibble on both digits
    for (int n = 1; n <= 256 * TICK + 40; n++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      chk_cycle(n);
      // R6: one cycle after the wrap the count reads 00 on both digits
      if (n == 256 * TICK) chk("R6 wrap", int'(seg_o), 'h3F);
      // R5: count 0x12 shown on its upper digit during the first upper half
      if (n == 18 * TICK + HALF) chk("R5 upper digit of 12", int'(seg_o), 'h06);
    end
    // mid-run asynchronous reset
    @(negedge clk_i);
    #3 rst_ni = 1'b0;
    #2;
    chk("R1 async select", int'(digit_sel_o), 0);
    chk("R1 async segments", int'(seg_o), 'h3F);
    @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int n = 1; n <= 40 * TICK; n++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      chk_cycle(n);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule